// File: doc/BRIEF.md
# Dual-Bus Command and Event Mailbox

This block is a word-addressed register file that lets a host processor and an embedded I2C controller processor exchange work for two independent I2C buses. The host writes a command word into the slot belonging to one bus. The controller is told of it by a one-cycle strobe that carries the bus index, and it sees the command already split into its fields. A single data window of eight words is shared by both buses. It carries inline payload, or, for transfers that go through system memory, a 64-bit buffer pointer in its two lowest words.

In the other direction, the controller posts a result word into the event slot of the bus concerned and loads a nonzero value into the interrupt-raise register, which drives a level interrupt to the host. The host treats any nonzero event slot as pending and scans bus 0 before bus 1. It acknowledges by writing zero to the event slot and to the interrupt-raise register. An interrupt with both event slots empty is spurious and is cleared the same way. At teardown the host writes zero over every slot through the same port.

Top module: `mbx_dual_bus`

## Requirements
- R1: After reset every command, data, event, debug and interrupt-raise register reads zero, `irq_o` is low and `cmd_stb_o` is low.
- R2: A host write to byte offset 0x10500 (bus 0) or 0x10504 (bus 1) stores the word in that bus's command register, reads back unchanged, appears on `ctl_cmd_o` (bus b in bits 32b+31:32b) and leaves the other bus's command register alone.
- R3: A host write to command register b makes `cmd_stb_o` high for exactly the next cycle with `cmd_stb_bus_o` = b. Writes to any other offset make no strobe.
- R4: The eight shared data words at offsets 0x10508 through 0x10524 are host read/write, and word i appears on `ctl_data_o` bits 32i+31:32i.
- R5: A controller write to event slot b (`ctl_evt_we_i[b]`) is readable by the host at offset 0x10684 + 4b on the next cycle.
- R6: A host write to an event slot or to the interrupt-raise register overrides a controller write to the same register in the same cycle, so a host zero acknowledges the slot even when the controller writes at the same moment.
- R7: `irq_o` is high exactly while the interrupt-raise register (offset 0x10690, loaded by the controller) is nonzero. A host write of zero there drops `irq_o` in the next cycle, including the spurious case with both event slots at zero.
- R8: The status word at offset 0x10694 is read-only: bit b is 1 when event slot b is nonzero, bit 2 is 1 when the interrupt-raise register is nonzero, and the other bits are 0. Host writes to it have no effect.
- R9: The debug word at offset 0x1068C is loaded only by the controller. The host reads it, and host writes to it have no effect.
- R10: Offsets outside the map, the reserved offset 0x10680, and any address whose two low bits are nonzero all read as zero and ignore writes.
- R11: For the command last strobed, the field outputs present bits 3:0 as opcode, 7:4 as bus tag, 15:8 as target address, 27:16 as length, 30:28 as speed code and bit 31 as the inline flag (1 = payload in the data words, 0 = memory pointer).
- R12: `buf_addr_o` carries data word 1 as its upper 32 bits and data word 0 as its lower 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | ADDR_W | Host byte address |
| h_we | input | 1 | Host write enable |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational on h_addr) |
| ctl_evt_we_i | input | N_BUS | Controller write enable per event slot |
| ctl_evt_wdata_i | input | 32*N_BUS | Controller event words, slot b in bits 32b+31:32b |
| ctl_irq_we_i | input | 1 | Controller write to the interrupt-raise register |
| ctl_irq_wdata_i | input | 32 | Interrupt-raise value |
| ctl_dbg_we_i | input | 1 | Controller write to the debug word |
| ctl_dbg_wdata_i | input | 32 | Debug value |
| ctl_cmd_o | output | 32*N_BUS | All command registers |
| ctl_data_o | output | 32*N_DATA | All shared data words |
| buf_addr_o | output | 64 | Memory pointer from data words 1 and 0 |
| cmd_stb_o | output | 1 | One-cycle command-written strobe |
| cmd_stb_bus_o | output | BUS_W | Bus index of the strobed command |
| cmd_op_o | output | 4 | Opcode field of the strobed command |
| cmd_tag_o | output | 4 | Bus tag field |
| cmd_target_o | output | 8 | Target address field |
| cmd_len_o | output | 12 | Length field |
| cmd_speed_o | output | 3 | Speed code field |
| cmd_inline_o | output | 1 | Memory type flag |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its default parameters: two buses, eight data words and a 20-bit address. This places the register map at the offsets listed above. Both command slots, both event slots and the first and last data words can then be reached, together with the addresses just outside the data window and the event window. With two buses the status word has both event bits and the interrupt bit, so the spurious-interrupt case and the contested acknowledge can both be driven, and the result can be observed at the ports.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_DATA,
        SEL_EVT,
        SEL_DBG,
        SEL_IGEN,
        SEL_STAT
    } sel_e;

    // Command word, most significant field first.
    typedef struct packed {
        logic        inline_data;
        logic [2:0]  speed;
        logic [11:0] len;
        logic [7:0]  target;
        logic [3:0]  bus_tag;
        logic [3:0]  op;
    } cmd_word_t;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned N_BUS    = 2,
    parameter int unsigned N_DATA   = 8,
    parameter int unsigned CMD_BASE = 32'h10500,
    parameter int unsigned EVT_BASE = 32'h10680,
    parameter int unsigned IDX_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned WW = ADDR_W - 2;
    localparam logic [WW-1:0] CMD_LO  = WW'(CMD_BASE / 4);
    localparam logic [WW-1:0] DAT_LO  = WW'(CMD_BASE / 4 + N_BUS);
    localparam logic [WW-1:0] DAT_HI  = WW'(CMD_BASE / 4 + N_BUS + N_DATA);
    localparam logic [WW-1:0] EVT_LO  = WW'(EVT_BASE / 4 + 1);
    localparam logic [WW-1:0] EVT_HI  = WW'(EVT_BASE / 4 + 1 + N_BUS);
    localparam logic [WW-1:0] DBG_W   = EVT_HI;
    localparam logic [WW-1:0] IGEN_W  = WW'(EVT_BASE / 4 + 2 + N_BUS);
    localparam logic [WW-1:0] STAT_W  = WW'(EVT_BASE / 4 + 3 + N_BUS);

    logic [WW-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (word >= CMD_LO && word < DAT_LO) begin
                sel = SEL_CMD;
                idx = IDX_W'(word - CMD_LO);
            end else if (word >= DAT_LO && word < DAT_HI) begin
                sel = SEL_DATA;
                idx = IDX_W'(word - DAT_LO);
            end else if (word >= EVT_LO && word < EVT_HI) begin
                sel = SEL_EVT;
                idx = IDX_W'(word - EVT_LO);
            end else if (word == DBG_W) begin
                sel = SEL_DBG;
            end else if (word == IGEN_W) begin
                sel = SEL_IGEN;
            end else if (word == STAT_W) begin
                sel = SEL_STAT;
            end
        end
    end

endmodule

// File: rtl/mbx_shared_reg.sv
module mbx_shared_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_we,
    input  logic [W-1:0] host_wdata,
    input  logic         ctl_we,
    input  logic [W-1:0] ctl_wdata,
    output logic [W-1:0] val_o
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (host_we)
            val_d = host_wdata;
        else if (ctl_we)
            val_d = ctl_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;

    // R6: a contested write resolves to the host value
    a_r6_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && ctl_we) |=> (val_o == $past(host_wdata)));

    // R5: an uncontested controller write lands one cycle later
    a_r5_ctl_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !host_we) |=> (val_o == $past(ctl_wdata)));

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && !host_we) |=> $stable(val_o));

endmodule

// File: rtl/mbx_dual_bus.sv
module mbx_dual_bus
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned N_BUS    = 2,
    parameter int unsigned N_DATA   = 8,
    parameter int unsigned CMD_BASE = 32'h10500,
    parameter int unsigned EVT_BASE = 32'h10680,
    localparam int unsigned BUS_W   = (N_BUS > 1) ? $clog2(N_BUS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     h_addr,
    input  logic                  h_we,
    input  logic [31:0]           h_wdata,
    output logic [31:0]           h_rdata,
    input  logic [N_BUS-1:0]      ctl_evt_we_i,
    input  logic [32*N_BUS-1:0]   ctl_evt_wdata_i,
    input  logic                  ctl_irq_we_i,
    input  logic [31:0]           ctl_irq_wdata_i,
    input  logic                  ctl_dbg_we_i,
    input  logic [31:0]           ctl_dbg_wdata_i,
    output logic [32*N_BUS-1:0]   ctl_cmd_o,
    output logic [32*N_DATA-1:0]  ctl_data_o,
    output logic [63:0]           buf_addr_o,
    output logic                  cmd_stb_o,
    output logic [BUS_W-1:0]      cmd_stb_bus_o,
    output logic [3:0]            cmd_op_o,
    output logic [3:0]            cmd_tag_o,
    output logic [7:0]            cmd_target_o,
    output logic [11:0]           cmd_len_o,
    output logic [2:0]            cmd_speed_o,
    output logic                  cmd_inline_o,
    output logic                  irq_o
);
    localparam int unsigned DAT_W = (N_DATA > 1) ? $clog2(N_DATA) : 1;
    localparam int unsigned IDX_W = (DAT_W > BUS_W) ? DAT_W : BUS_W;

    typedef struct packed {
        logic [N_BUS-1:0][31:0]  cmd;
        logic [N_DATA-1:0][31:0] data;
        logic                    stb;
        logic [BUS_W-1:0]        stb_bus;
    } state_t;

    state_t st_d, st_q;

    sel_e             sel;
    logic [IDX_W-1:0] idx;

    logic [N_BUS-1:0][31:0] evt_w;
    logic [31:0]            igen_w;
    logic [31:0]            dbg_w;
    logic [N_BUS-1:0]       evt_busy;
    cmd_word_t              cur_cmd;

    mbx_decode #(
        .ADDR_W(ADDR_W), .N_BUS(N_BUS), .N_DATA(N_DATA),
        .CMD_BASE(CMD_BASE), .EVT_BASE(EVT_BASE), .IDX_W(IDX_W)
    ) u_dec (
        .addr (h_addr),
        .sel  (sel),
        .idx  (idx)
    );

    // One event slot per bus, host write has priority.
    for (genvar b = 0; b < N_BUS; b++) begin : g_evt
        mbx_shared_reg #(.W(32)) u_evt (
            .clk        (clk),
            .rst_n      (rst_n),
            .host_we    (h_we && sel == SEL_EVT && BUS_W'(idx) == BUS_W'(b)),
            .host_wdata (h_wdata),
            .ctl_we     (ctl_evt_we_i[b]),
            .ctl_wdata  (ctl_evt_wdata_i[32*b +: 32]),
            .val_o      (evt_w[b])
        );
        assign evt_busy[b] = |evt_w[b];
    end

    mbx_shared_reg #(.W(32)) u_igen (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (h_we && sel == SEL_IGEN),
        .host_wdata (h_wdata),
        .ctl_we     (ctl_irq_we_i),
        .ctl_wdata  (ctl_irq_wdata_i),
        .val_o      (igen_w)
    );

    // Debug word: controller only.
    mbx_shared_reg #(.W(32)) u_dbg (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (1'b0),
        .host_wdata (32'h0),
        .ctl_we     (ctl_dbg_we_i),
        .ctl_wdata  (ctl_dbg_wdata_i),
        .val_o      (dbg_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (h_we) begin
            case (sel)
                SEL_CMD: begin
                    st_d.cmd[BUS_W'(idx)] = h_wdata;
                    st_d.stb              = 1'b1;
                    st_d.stb_bus          = BUS_W'(idx);
                end
                SEL_DATA: st_d.data[DAT_W'(idx)] = h_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        h_rdata = 32'h0;
        case (sel)
            SEL_CMD:  h_rdata = st_q.cmd[BUS_W'(idx)];
            SEL_DATA: h_rdata = st_q.data[DAT_W'(idx)];
            SEL_EVT:  h_rdata = evt_w[BUS_W'(idx)];
            SEL_DBG:  h_rdata = dbg_w;
            SEL_IGEN: h_rdata = igen_w;
            SEL_STAT: begin
                h_rdata[N_BUS-1:0] = evt_busy;
                h_rdata[N_BUS]     = |igen_w;
            end
            default:  h_rdata = 32'h0;
        endcase
    end

    assign cur_cmd       = cmd_word_t'(st_q.cmd[st_q.stb_bus]);
    assign ctl_cmd_o     = st_q.cmd;
    assign ctl_data_o    = st_q.data;
    assign buf_addr_o    = {st_q.data[1], st_q.data[0]};
    assign cmd_stb_o     = st_q.stb;
    assign cmd_stb_bus_o = st_q.stb_bus;
    assign cmd_op_o      = cur_cmd.op;
    assign cmd_tag_o     = cur_cmd.bus_tag;
    assign cmd_target_o  = cur_cmd.target;
    assign cmd_len_o     = cur_cmd.len;
    assign cmd_speed_o   = cur_cmd.speed;
    assign cmd_inline_o  = cur_cmd.inline_data;
    assign irq_o         = |igen_w;

    // R3: a strobe only follows a host command write
    a_r3_stb_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> $past(h_we && sel == SEL_CMD));

    // R3: a host command write always yields a strobe for that bus
    a_r3_stb_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && sel == SEL_CMD) |=> (cmd_stb_o && cmd_stb_bus_o == $past(BUS_W'(idx))));

    // R2: command registers hold without host writes
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !h_we |=> $stable(ctl_cmd_o));

    // R7: host zero to the interrupt-raise register drops the line
    a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && sel == SEL_IGEN && h_wdata == 32'h0) |=> !irq_o);

    // R10: unmapped decode reads zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (h_rdata == 32'h0));

endmodule

// File: tb/mbx_dual_bus_test.sv
module mbx_dual_bus_test;

    localparam int ADDR_W = 20;
    localparam int N_BUS  = 2;
    localparam int N_DATA = 8;
    localparam int NV     = 10;

    typedef struct packed {
        logic [19:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{20'h10500, 32'h1122_3344, 32'h1122_3344},
        '{20'h10504, 32'h5566_7788, 32'h5566_7788},
        '{20'h10508, 32'hA5A5_0001, 32'hA5A5_0001},
        '{20'h10524, 32'h0BAD_F00D, 32'h0BAD_F00D},
        '{20'h10680, 32'hFFFF_FFFF, 32'h0},
        '{20'h10528, 32'h0000_0001, 32'h0},
        '{20'h10502, 32'h0000_0009, 32'h0},
        '{20'h1068C, 32'h0000_0077, 32'h0},
        '{20'h10694, 32'h0000_000F, 32'h0},
        '{20'h10684, 32'h0000_0000, 32'h0}
    };
    localparam string TAGS [NV] = '{"R2", "R2", "R4", "R4", "R10",
                                    "R10", "R10", "R9", "R8", "R6"};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ADDR_W-1:0]    h_addr = '0;
    logic                 h_we = 1'b0;
    logic [31:0]          h_wdata = '0;
    logic [31:0]          h_rdata;
    logic [N_BUS-1:0]     ctl_evt_we = '0;
    logic [32*N_BUS-1:0]  ctl_evt_wdata = '0;
    logic                 ctl_irq_we = 1'b0;
    logic [31:0]          ctl_irq_wdata = '0;
    logic                 ctl_dbg_we = 1'b0;
    logic [31:0]          ctl_dbg_wdata = '0;
    logic [32*N_BUS-1:0]  ctl_cmd;
    logic [32*N_DATA-1:0] ctl_data;
    logic [63:0]          buf_addr;
    logic                 cmd_stb;
    logic [0:0]           cmd_stb_bus;
    logic [3:0]           cmd_op, cmd_tag;
    logic [7:0]           cmd_target;
    logic [11:0]          cmd_len;
    logic [2:0]           cmd_speed;
    logic                 cmd_inline;
    logic                 irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    mbx_dual_bus uut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .ctl_evt_we_i(ctl_evt_we), .ctl_evt_wdata_i(ctl_evt_wdata),
        .ctl_irq_we_i(ctl_irq_we), .ctl_irq_wdata_i(ctl_irq_wdata),
        .ctl_dbg_we_i(ctl_dbg_we), .ctl_dbg_wdata_i(ctl_dbg_wdata),
        .ctl_cmd_o(ctl_cmd), .ctl_data_o(ctl_data), .buf_addr_o(buf_addr),
        .cmd_stb_o(cmd_stb), .cmd_stb_bus_o(cmd_stb_bus),
        .cmd_op_o(cmd_op), .cmd_tag_o(cmd_tag), .cmd_target_o(cmd_target),
        .cmd_len_o(cmd_len), .cmd_speed_o(cmd_speed), .cmd_inline_o(cmd_inline),
        .irq_o(irq)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic hwrite(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        h_addr = a; h_wdata = d; h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic hread(input logic [19:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic ctl_evt(input int b, input logic [31:0] d);
        @(negedge clk);
        ctl_evt_we[b] = 1'b1; ctl_evt_wdata[32*b +: 32] = d;
        @(negedge clk);
        ctl_evt_we = '0;
    endtask

    task automatic ctl_irq(input logic [31:0] d);
        @(negedge clk);
        ctl_irq_we = 1'b1; ctl_irq_wdata = d;
        @(negedge clk);
        ctl_irq_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 stb", cmd_stb, 0);
        hread(20'h10500, rd); check("R1 cmd0", rd, 0);
        hread(20'h10524, rd); check("R1 data7", rd, 0);
        hread(20'h10690, rd); check("R1 igen", rd, 0);
        hread(20'h10694, rd); check("R1 status", rd, 0);

        // Table walk: write, then read back
        for (int i = 0; i < NV; i++) begin
            hwrite(TBL[i].addr, TBL[i].wd);
            hread(TBL[i].addr, rd);
            check(TAGS[i], rd, TBL[i].exp);
        end

        // R10 misaligned write did not reach cmd0; R2 controller view
        hread(20'h10500, rd); check("R10 cmd0 intact", rd, 32'h1122_3344);
        check("R2 ctl_cmd", ctl_cmd, 64'h5566_7788_1122_3344);
        check("R4 ctl_data w0", ctl_data[31:0], 32'hA5A5_0001);
        check("R4 ctl_data w7", ctl_data[255:224], 32'h0BAD_F00D);

        // R3 / R11 strobe and fields
        hwrite(20'h10504, 32'h8ABC_1231);
        check("R3 stb high", cmd_stb, 1);
        check("R3 stb bus", cmd_stb_bus, 1);
        check("R11 fields", {cmd_inline, cmd_speed, cmd_len, cmd_target, cmd_tag, cmd_op},
              {1'b1, 3'd0, 12'hABC, 8'h12, 4'h3, 4'h1});
        @(negedge clk);
        check("R3 stb one cycle", cmd_stb, 0);
        hwrite(20'h10500, 32'h3456_7A02);
        check("R3 stb bus0", {cmd_stb, cmd_stb_bus}, 2'b10);
        check("R11 fields bus0", {cmd_inline, cmd_speed, cmd_len, cmd_target, cmd_tag, cmd_op},
              {1'b0, 3'd3, 12'h456, 8'h7A, 4'h0, 4'h2});
        check("R2 other bus intact", ctl_cmd[63:32], 32'h8ABC_1231);
        hwrite(20'h1050C, 32'h0000_0001);
        check("R3 no stb on data", cmd_stb, 0);

        // R12 buffer pointer
        check("R12 buf_addr", buf_addr, 64'h0000_0001_A5A5_0001);

        // R5 / R8 events and status
        ctl_evt(0, 32'h0000_1234);
        hread(20'h10684, rd); check("R5 evt0", rd, 32'h1234);
        hread(20'h10688, rd); check("R5 evt1 empty", rd, 0);
        hread(20'h10694, rd); check("R8 status evt0", rd, 32'h1);
        ctl_irq(32'h1);
        check("R7 irq up", irq, 1);
        hread(20'h10694, rd); check("R8 status evt0+irq", rd, 32'h5);
        ctl_evt(1, 32'h0000_00A0);
        hread(20'h10694, rd); check("R8 status both", rd, 32'h7);

        // R6 contested acknowledge of slot 0
        @(negedge clk);
        h_addr = 20'h10684; h_wdata = 32'h0; h_we = 1'b1;
        ctl_evt_we[0] = 1'b1; ctl_evt_wdata[31:0] = 32'hFFFF;
        @(negedge clk);
        h_we = 1'b0; ctl_evt_we = '0;
        hread(20'h10684, rd); check("R6 host wins evt", rd, 0);

        // R6 contested interrupt-raise write, then R7 clear
        @(negedge clk);
        h_addr = 20'h10690; h_wdata = 32'h0; h_we = 1'b1;
        ctl_irq_we = 1'b1; ctl_irq_wdata = 32'h3;
        @(negedge clk);
        h_we = 1'b0; ctl_irq_we = 1'b0;
        check("R6 host wins irq", irq, 0);
        hwrite(20'h10688, 32'h0);

        // R7 spurious interrupt with both slots empty
        ctl_irq(32'h7);
        hread(20'h10694, rd); check("R8 spurious status", rd, 32'h4);
        check("R7 spurious irq", irq, 1);
        hwrite(20'h10690, 32'h0);
        check("R7 irq cleared", irq, 0);

        // R9 debug word from controller, host write ignored
        @(negedge clk);
        ctl_dbg_we = 1'b1; ctl_dbg_wdata = 32'hDEAD_0001;
        @(negedge clk);
        ctl_dbg_we = 1'b0;
        hwrite(20'h1068C, 32'h0);
        hread(20'h1068C, rd); check("R9 debug", rd, 32'hDEAD_0001);

        // R10 far unmapped
        hwrite(20'h00000, 32'hFFFF_FFFF);
        hread(20'h00000, rd); check("R10 low unmapped", rd, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule